// File: doc/BRIEF.md
# Prime-Length 17-Point DFT Engine (Cyclic Convolution Form)

This block computes the complex discrete Fourier transform of a 17-sample frame. Because 17 is prime, the 16 non-zero bins can be rewritten as one cyclic convolution. The sample index is re-expressed as a power of the generator 3 modulo 17. Incoming samples are parked directly in a 16-entry ring of registers, at the slot given by their discrete logarithm. Sample 0 and a running sum for the DC bin are held apart from the ring. Each tap of the ring has a fixed complex weight. The ring then advances one slot per clock. In every step, all slots are multiplied by their weights, the products are summed, sample 0 is added, and the result is one output bin.

A frame of 17 samples is accepted with a valid/ready handshake in natural index order. While results are being produced, the block reports busy and refuses input. It emits 17 results back to back. Each result carries the bin number it belongs to: DC first, then the convolution bins in ring order. Results are scaled by 1/4, rounded half-up and clamped to 18-bit signed.

Top module: `prime_conv_dft`

## Requirements
- R1: After reset, outValid is 0, inReady is 1 and busy is 0.
- R2: While inReady is high the block takes exactly 17 samples (indices 0 to 16, in acceptance order). It then holds inReady low and busy high for as long as results are being presented. inReady returns high in the cycle after the last result.
- R3: The 17 results appear in 17 consecutive cycles. The first one is valid in the cycle right after the clock edge that captured sample 16.
- R4: The first result of a frame carries outBin 0. The second carries 1. Each later tag equals the previous tag times 6 modulo 17, which gives the sequence 0,1,6,2,12,4,7,8,14,16,11,15,5,13,10,9,3.
- R5: The bin-0 result equals floor(S/4 + 1/2) in each of its real and imaginary parts, where S is the exact sum of the 17 samples.
- R6: For k from 1 to 16, the result lies within 10 LSB of X[k]/4, where X[k] = sum over n of x[n]·exp(-j·2π·n·k/17).
- R7: Any result beyond the 18-bit range is clamped to 131071 or -131072.
- R8: A high inValid while inReady is low has no effect on the current results or on the next frame.
- R9: Idle cycles (inValid low) between samples while loading do not change the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample offered |
| inReady | output | 1 | Block takes a sample on this edge if inValid is high |
| inRe | input | 16 | Sample real part, signed |
| inIm | input | 16 | Sample imaginary part, signed |
| busy | output | 1 | Frame being transformed or results still pending |
| outValid | output | 1 | Result present |
| outBin | output | 5 | Frequency bin of the present result |
| outRe | output | 18 | Result real part, signed, scaled by 1/4 |
| outIm | output | 18 | Result imaginary part, signed, scaled by 1/4 |

## Verification
The bench records the cycle at which sample 16 is taken. The DC result is due exactly one cycle later, and each convolution bin follows one cycle after the one before it. Ready comes back one cycle after bin 3, the last in the sequence. All inputs are driven, and all outputs sampled, on the falling clock edge. The bench captures results cycle by cycle against these expected cycle numbers rather than waiting for them. Values are compared with a floating-point DFT computed in the bench. DC must match exactly, and the other bins must fall within the stated tolerance.

// File: rtl/pcdft_pkg.sv
package pcdft_pkg;

  localparam int PTS       = 17;
  localparam int ROOT      = 3;
  localparam int CONV_LEN  = PTS - 1;
  localparam int IDX_W     = $clog2(PTS);
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;

  typedef enum logic [1:0] {S_LOAD, S_RUN, S_DRAIN} state_t;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] loadIdx;
    logic             emitDc;
    logic             emitConv;
    logic             rotate;
    logic [IDX_W-1:0] binTag;
  } strobe_t;

  function automatic int powMod(int base, int e, int m);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * base) % m;
    return r;
  endfunction

  function automatic int invMod(int a, int m);
    for (int c = 1; c < m; c++) if ((a * c) % m == 1) return c;
    return 0;
  endfunction

  function automatic int foldIdx(int k);
    return (k > PTS / 2) ? PTS - k : k;
  endfunction

  // cos(2*pi*k/17) in Q1.14
  function automatic int cosQ(int k);
    case (foldIdx(k))
      0: return 16384;
      1: return 15278;
      2: return 12108;
      3: return 7303;
      4: return 1512;
      5: return -4484;
      6: return -9874;
      7: return -13930;
      default: return -16105;
    endcase
  endfunction

  // sin(2*pi*k/17) in Q1.14
  function automatic int sinQ(int k);
    int mag;
    case (foldIdx(k))
      0: mag = 0;
      1: mag = 5919;
      2: mag = 11038;
      3: mag = 14666;
      4: mag = 16314;
      5: mag = 15759;
      6: mag = 13075;
      7: mag = 8625;
      default: mag = 3011;
    endcase
    return (k > PTS / 2) ? -mag : mag;
  endfunction

endpackage

// File: rtl/pcdft_ctrl.sv
module pcdft_ctrl
  import pcdft_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  output logic    busy,
  output strobe_t strb
);

  localparam int               STEP_INV = invMod(ROOT, PTS);
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(PTS - 1);

  state_t           state;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] bin;
  logic             accept;

  assign inReady = (state == S_LOAD);
  assign busy    = (state != S_LOAD);
  assign accept  = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_LOAD;
      cnt   <= '0;
      bin   <= '0;
    end else begin
      case (state)
        S_LOAD: begin
          if (accept) begin
            if (cnt == LAST) begin
              cnt   <= '0;
              bin   <= '0;
              state <= S_RUN;
            end else begin
              cnt <= cnt + IDX_W'(1);
            end
          end
        end
        S_RUN: begin
          if (cnt == '0) bin <= IDX_W'(1);
          else           bin <= IDX_W'((int'(bin) * STEP_INV) % PTS);
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= S_DRAIN;
          end else begin
            cnt <= cnt + IDX_W'(1);
          end
        end
        default: state <= S_LOAD;
      endcase
    end
  end

  always_comb begin
    strb.load     = accept;
    strb.loadIdx  = cnt;
    strb.emitDc   = (state == S_RUN) && (cnt == '0);
    strb.emitConv = (state == S_RUN) && (cnt != '0);
    strb.rotate   = strb.emitConv;
    strb.binTag   = bin;
  end

endmodule

// File: rtl/pcdft_datapath.sv
module pcdft_datapath
  import pcdft_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int OUT_W     = 18,
  parameter int OUT_SHIFT = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                    outValid,
  output logic [IDX_W-1:0]        outBin,
  output logic signed [OUT_W-1:0] outRe,
  output logic signed [OUT_W-1:0] outIm
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(PTS) + 1;
  localparam int DC_W   = DATA_W + $clog2(PTS) + 1;
  localparam int SHIFT  = COEF_FRAC + OUT_SHIFT;
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) << (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = -(ACC_W'(1) << (OUT_W - 1));

  logic signed [DATA_W-1:0] rotRe [CONV_LEN];
  logic signed [DATA_W-1:0] rotIm [CONV_LEN];
  logic signed [DATA_W-1:0] x0Re, x0Im;
  logic signed [DC_W-1:0]   dcRe, dcIm;
  logic [IDX_W-1:0]         tapIdx [CONV_LEN];
  logic signed [ACC_W-1:0]  termRe [CONV_LEN];
  logic signed [ACC_W-1:0]  termIm [CONV_LEN];
  logic signed [ACC_W-1:0]  convRe, convIm, dcWideRe, dcWideIm;

  // tap p holds sample 3^p mod 17 and weights it by W17^(3^p mod 17)
  for (genvar p = 0; p < CONV_LEN; p++) begin : g_tap
    localparam int KP = powMod(ROOT, p, PTS);
    localparam logic signed [COEF_W-1:0] WC = COEF_W'(cosQ(KP));
    localparam logic signed [COEF_W-1:0] WS = COEF_W'(sinQ(KP));
    assign tapIdx[p] = IDX_W'(KP);
    // (re + j im) * (WC - j WS)
    assign termRe[p] = ACC_W'(rotRe[p]) * ACC_W'(WC) + ACC_W'(rotIm[p]) * ACC_W'(WS);
    assign termIm[p] = ACC_W'(rotIm[p]) * ACC_W'(WC) - ACC_W'(rotRe[p]) * ACC_W'(WS);
  end

  always_ff @(posedge clk) begin
    if (strb.load) begin
      if (strb.loadIdx == '0) begin
        x0Re <= inRe;
        x0Im <= inIm;
        dcRe <= DC_W'(inRe);
        dcIm <= DC_W'(inIm);
      end else begin
        dcRe <= dcRe + DC_W'(inRe);
        dcIm <= dcIm + DC_W'(inIm);
      end
      for (int p = 0; p < CONV_LEN; p++) begin
        if (strb.loadIdx == tapIdx[p]) begin
          rotRe[p] <= inRe;
          rotIm[p] <= inIm;
        end
      end
    end else if (strb.rotate) begin
      for (int p = 0; p < CONV_LEN; p++) begin
        rotRe[p] <= rotRe[(p + 1) % CONV_LEN];
        rotIm[p] <= rotIm[(p + 1) % CONV_LEN];
      end
    end
  end

  always_comb begin
    convRe = ACC_W'(x0Re) <<< COEF_FRAC;
    convIm = ACC_W'(x0Im) <<< COEF_FRAC;
    for (int p = 0; p < CONV_LEN; p++) begin
      convRe = convRe + termRe[p];
      convIm = convIm + termIm[p];
    end
    dcWideRe = ACC_W'(dcRe) <<< COEF_FRAC;
    dcWideIm = ACC_W'(dcIm) <<< COEF_FRAC;
  end

  function automatic logic signed [OUT_W-1:0] roundSat(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] r;
    r = (v + HALF) >>> SHIFT;
    if (r > OUT_MAX) r = OUT_MAX;
    else if (r < OUT_MIN) r = OUT_MIN;
    return r[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outBin   <= '0;
      outRe    <= '0;
      outIm    <= '0;
    end else begin
      outValid <= strb.emitDc || strb.emitConv;
      if (strb.emitDc) begin
        outBin <= strb.binTag;
        outRe  <= roundSat(dcWideRe);
        outIm  <= roundSat(dcWideIm);
      end else if (strb.emitConv) begin
        outBin <= strb.binTag;
        outRe  <= roundSat(convRe);
        outIm  <= roundSat(convIm);
      end
    end
  end

endmodule

// File: rtl/prime_conv_dft.sv
module prime_conv_dft
  import pcdft_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int OUT_W     = 18,
  parameter int OUT_SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                     busy,
  output logic                     outValid,
  output logic [IDX_W-1:0]         outBin,
  output logic signed [OUT_W-1:0]  outRe,
  output logic signed [OUT_W-1:0]  outIm
);

  strobe_t strb;

  pcdft_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .busy    (busy),
    .strb    (strb)
  );

  pcdft_datapath #(
    .DATA_W    (DATA_W),
    .OUT_W     (OUT_W),
    .OUT_SHIFT (OUT_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inRe     (inRe),
    .inIm     (inIm),
    .outValid (outValid),
    .outBin   (outBin),
    .outRe    (outRe),
    .outIm    (outIm)
  );

endmodule

// File: rtl/pcdft_checker.sv
module pcdft_checker
  import pcdft_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic [IDX_W-1:0] outBin
);

  logic [5:0] runLen;
  logic [5:0] accCnt;

  function automatic int stepBin(int b);
    return (b == 0) ? 1 : (b * invMod(ROOT, PTS)) % PTS;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
      accCnt <= '0;
    end else begin
      runLen <= outValid ? runLen + 6'd1 : 6'd0;
      if (inValid && inReady) accCnt <= accCnt + 6'd1;
      else if (outValid)      accCnt <= '0;
    end
  end

  AST_NO_READY_WHILE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R2
  AST_FRAME_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> accCnt == 6'd17); // R2
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> runLen == 6'd17); // R3
  AST_DC_LEADS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outBin == '0); // R4
  AST_BIN_WALK: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> int'(outBin) == stepBin(int'($past(outBin)))); // R4
  AST_BIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> int'(outBin) < PTS); // R4

endmodule

bind prime_conv_dft pcdft_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outBin   (outBin)
);

// File: tb/test_prime_conv_dft.sv
`timescale 1ns/1ps
module test_prime_conv_dft;

  localparam int PTS = 17;
  localparam int TOL = 10;
  localparam int NSTIM = 7;
  // kind, amplitude, parameter
  localparam int STIM [NSTIM][3] = '{
    '{0, 20000, 0},
    '{0, 12000, 5},
    '{1, 9000, -4000},
    '{2, 7000, 3},
    '{3, 30000, 1},
    '{3, 25000, 2},
    '{4, 15000, 0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic signed [15:0] inRe = '0;
  logic signed [15:0] inIm = '0;
  logic busy;
  logic outValid;
  logic [4:0] outBin;
  logic signed [17:0] outRe;
  logic signed [17:0] outIm;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int xr [PTS];
  int xi [PTS];
  int capBin [PTS];
  int capRe [PTS];
  int capIm [PTS];
  int capCnt, lastAcc, firstOut, lastOut, overlap;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prime_conv_dft i_prime_conv_dft (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inRe(inRe), .inIm(inIm), .busy(busy), .outValid(outValid),
    .outBin(outBin), .outRe(outRe), .outIm(outIm)
  );

  task automatic checkInt(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkNear(string req, string what, int act, int exp, int tol);
    int d = act - exp;
    checks++;
    if (d > tol || d < -tol) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (tol %0d)", req, what, act, exp, tol);
    end
  endtask

  function automatic int satQ(real v);
    int r = $rtoi($floor(v / 4.0 + 0.5));
    if (r > 131071) r = 131071;
    if (r < -131072) r = -131072;
    return r;
  endfunction

  task automatic buildFrame(int kind, int a, int b);
    for (int n = 0; n < PTS; n++) begin
      longint h, g;
      real th;
      case (kind)
        0: begin xr[n] = (n == b) ? a : 0; xi[n] = 0; end
        1: begin xr[n] = a; xi[n] = b; end
        2: begin
          th = 2.0 * 3.14159265358979 * b * n / PTS;
          xr[n] = $rtoi($floor(a * $cos(th) + 0.5));
          xi[n] = $rtoi($floor(a * $sin(th) + 0.5));
        end
        3: begin
          h = (n + 1) * 7919 + b * 104729;
          g = (n + 3) * 6007 + b * 33391;
          h = (h * h + 12345) % 65521;
          g = (g * g + 777) % 65519;
          xr[n] = int'(h % (2 * a + 1)) - a;
          xi[n] = int'(g % (2 * a + 1)) - a;
        end
        default: begin
          xr[n] = (n % 2 == 0) ? a : -a;
          xi[n] = (n % 3 == 0) ? a / 2 : -a / 2;
        end
      endcase
    end
  endtask

  task automatic runFrame(bit gaps, bit junk);
    capCnt = 0;
    overlap = 0;
    for (int n = 0; n < PTS; n++) begin
      @(negedge clk);
      if (gaps && (n % 4 == 2)) begin
        inValid = 1'b0;
        inRe = 16'sh5a5a;
        repeat (2) @(negedge clk);
      end
      inValid = 1'b1;
      inRe = 16'(xr[n]);
      inIm = 16'(xi[n]);
      while (!inReady) @(negedge clk);
    end
    for (int c = 0; c < 40 && capCnt < PTS; c++) begin
      @(negedge clk);
      if (c == 0) lastAcc = cyc;
      if (outValid) begin
        if (capCnt == 0) firstOut = cyc;
        lastOut = cyc;
        capBin[capCnt] = int'(outBin);
        capRe[capCnt] = int'(outRe);
        capIm[capCnt] = int'(outIm);
        capCnt++;
        if (inReady || !busy) overlap++;
      end
      if (junk && capCnt < PTS) begin
        inValid = 1'b1;
        inRe = 16'($urandom);
        inIm = 16'($urandom);
      end else begin
        inValid = 1'b0;
      end
    end
    checkInt("R3", "result count", capCnt, PTS);
    checkInt("R3", "first result delay", firstOut - lastAcc, 1);
    checkInt("R3", "burst span", lastOut - firstOut, PTS - 1);
    checkInt("R2", "ready or idle during results", overlap, 0);
    @(negedge clk);
    checkInt("R2", "inReady after burst", int'(inReady), 1);
    checkInt("R2", "busy after burst", int'(busy), 0);
  endtask

  task automatic checkValues(string req);
    int bin = 0;
    for (int i = 0; i < PTS; i++) begin
      real sr = 0.0, si = 0.0;
      checkInt("R4", "bin tag", capBin[i], bin);
      for (int n = 0; n < PTS; n++) begin
        real th = -2.0 * 3.14159265358979 * n * bin / PTS;
        sr += xr[n] * $cos(th) - xi[n] * $sin(th);
        si += xr[n] * $sin(th) + xi[n] * $cos(th);
      end
      if (bin == 0) begin
        sr = 0.0; si = 0.0;
        for (int n = 0; n < PTS; n++) begin sr += xr[n]; si += xi[n]; end
        checkInt("R5", {req, " DC re"}, capRe[i], satQ(sr));
        checkInt("R5", {req, " DC im"}, capIm[i], satQ(si));
      end else begin
        checkNear("R6", {req, " bin re"}, capRe[i], satQ(sr), TOL);
        checkNear("R6", {req, " bin im"}, capIm[i], satQ(si), TOL);
      end
      bin = (bin == 0) ? 1 : (bin * 6) % PTS;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkInt("R1", "outValid after reset", int'(outValid), 0);
    checkInt("R1", "inReady after reset", int'(inReady), 1);
    checkInt("R1", "busy after reset", int'(busy), 0);

    for (int s = 0; s < NSTIM; s++) begin
      buildFrame(STIM[s][0], STIM[s][1], STIM[s][2]);
      runFrame(1'b0, 1'b0);
      checkValues("table");
    end

    // R7 positive and negative clamping on the DC bin
    buildFrame(1, 32767, -32768);
    runFrame(1'b0, 1'b0);
    checkInt("R7", "DC re clamp high", capRe[0], 131071);
    checkInt("R7", "DC im clamp low", capIm[0], -131072);
    checkValues("saturate");

    // R8 inValid during busy is ignored, this frame and the next
    buildFrame(3, 28000, 5);
    runFrame(1'b0, 1'b1);
    checkValues("R8 junk frame");
    buildFrame(0, 16000, 9);
    runFrame(1'b0, 1'b0);
    checkValues("R8 after junk");

    // R9 idle gaps during loading
    buildFrame(3, 30000, 1);
    runFrame(1'b1, 1'b0);
    checkValues("R9 gaps");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule